// File: doc/BRIEF.md
# Configurable Per-Pin I/O Port

This block is a microcontroller-facing I/O port of up to eight pins. A simple parallel register bus carries an address, a write strobe, a read strobe and a data byte. Through it the controller sets three per-pin configuration words: output source, direction and drive style. It also sets a data-out word and reads back the synchronized state of the pins. Bit n of every word belongs to pin n.

Each pin has three choices. It drives either the controller's data-out bit or an address bit supplied from outside. Its output enable comes from the direction bit, unless an external enable term is active, in which case the pin drives. Its output is either push-pull or emulated open drain. The block produces per-pin output value, output enable and drive-style signals for a tristate pad wrapper. Parameters control three things: whether the source-select word exists, whether the external enable override exists, and how many direction bits are implemented.

Top module: `cfg_io_port`

## Requirements
- R1: While rst_ni is low, every configuration word, the data-out word and the synchronizer hold 0. With ext_oe_i low, pad_oe_o is 0 and every read returns 0.
- R2: Registers are selected only when addr_i[7:3] equals BASE[7:3], and addr_i[2:0] is the offset. The offsets are 0 for source select, 1 for direction, 2 for drive style and 3 for data-out. A write with wr_i high stores wdata_i at the next clock edge, and a read returns the stored word combinationally. Writes with any other upper address are ignored.
- R3: If source-select bit n is 0, pad_out_o[n] follows data-out bit n. If it is 1, pad_out_o[n] follows addr_bit_i[n]. This holds for push-pull pins.
- R4: With ext_oe_i[n] low, pad_oe_o[n] equals direction bit n (1 = output) for push-pull pins.
- R5: When the override is present and ext_oe_i[n] is high, the pin is enabled as an output whatever its direction bit.
- R6: If drive-style bit n is 1, open_drain_o[n] is 1 and pad_out_o[n] is 0. In that case pad_oe_o[n] is 1 only when the pin is enabled and its selected value is 0. Drive style changes only by a write.
- R7: A read at offset 4 returns pin_i as it was sampled two clock edges earlier, whatever the direction setting.
- R8: With DIR_BITS = 4, direction bits 7..4 read as 0, ignore writes and leave the pins as inputs.
- R9: With HAS_CTRL = 0, offset 0 reads 0, writes to it are ignored and every pin drives its data-out bit.
- R10: With HAS_OE_OVR = 0, ext_oe_i has no effect on pad_oe_o.
- R11: Offsets 5 to 7 read 0, and rdata_o is 0 whenever rd_i is low or the upper address does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus address: upper bits select the block, low 3 bits the offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| addr_bit_i | input | NUM_PINS | Per-pin address bit driven in address-out mode |
| ext_oe_i | input | NUM_PINS | Per-pin external output-enable term, active high |
| pin_i | input | NUM_PINS | Pad input level |
| pad_out_o | output | NUM_PINS | Value to drive on the pad |
| pad_oe_o | output | NUM_PINS | Pad driver enable |
| open_drain_o | output | NUM_PINS | Pin is in open-drain drive style |

## Verification
The assertions assume that ext_oe_i is held low while reset is asserted. Under that assumption the no-drive-in-reset property is meaningful. They also assume the strobes are synchronous to clk_i, so that a drive-style change can only follow a sampled write. The stimulus changes every input one time unit after a rising edge and keeps ext_oe_i at 0 during reset. Two instances share the bus, one with every feature and one narrow instance without the source-select word and without the override. A behavioural model checks both instances against the same random and directed traffic.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;
  localparam int unsigned OFS_W = 3;
  typedef enum logic [OFS_W-1:0] {
    OFS_SRC  = 3'd0,
    OFS_DIR  = 3'd1,
    OFS_DRV  = 3'd2,
    OFS_DOUT = 3'd3,
    OFS_PIN  = 3'd4
  } ofs_e;
endpackage

// File: rtl/cfg_io_regs.sv
module cfg_io_regs #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_PINS = 8,
  parameter bit          HAS_CTRL = 1'b1,
  parameter int unsigned DIR_BITS = NUM_PINS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  cfg_io_pkg::ofs_e      ofs_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [NUM_PINS-1:0]   src_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   drv_o,
  output logic [NUM_PINS-1:0]   dout_o
);
  import cfg_io_pkg::*;

  function automatic logic [NUM_PINS-1:0] low_mask(int unsigned n);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_PINS; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_PINS-1:0] SRC_MASK = HAS_CTRL ? '1 : '0;
  localparam logic [NUM_PINS-1:0] DIR_MASK = low_mask(DIR_BITS);

  logic [NUM_PINS-1:0] wbits;
  assign wbits = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dir_o  <= '0;
      drv_o  <= '0;
      dout_o <= '0;
    end else if (wr_en_i) begin
      case (ofs_i)
        OFS_SRC:  src_o  <= wbits & SRC_MASK;
        OFS_DIR:  dir_o  <= wbits & DIR_MASK;
        OFS_DRV:  drv_o  <= wbits;
        OFS_DOUT: dout_o <= wbits;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_io_sync.sv
module cfg_io_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cfg_io_pin.sv
module cfg_io_pin #(
  parameter bit HAS_OVR = 1'b1
) (
  input  logic src_i,
  input  logic dir_i,
  input  logic drv_i,
  input  logic dout_i,
  input  logic addr_bit_i,
  input  logic ext_oe_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic open_drain_o
);
  logic val, ovr, en;

  assign val          = src_i ? addr_bit_i : dout_i;
  assign ovr          = HAS_OVR ? ext_oe_i : 1'b0;
  assign en           = ovr | dir_i;
  // open drain: never drive high, release instead
  assign pad_out_o    = drv_i ? 1'b0 : val;
  assign pad_oe_o     = en & (~drv_i | ~val);
  assign open_drain_o = drv_i;
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int unsigned          ADDR_W     = 8,
  parameter int unsigned          DATA_W     = 8,
  parameter int unsigned          NUM_PINS   = 8,
  parameter logic [ADDR_W-1:0]    BASE       = 8'h40,
  parameter bit                   HAS_CTRL   = 1'b1,
  parameter bit                   HAS_OE_OVR = 1'b1,
  parameter int unsigned          DIR_BITS   = NUM_PINS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   addr_bit_i,
  input  logic [NUM_PINS-1:0]   ext_oe_i,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   open_drain_o
);
  import cfg_io_pkg::*;

  localparam int unsigned HI_W = ADDR_W - OFS_W;

  logic                cs;
  ofs_e                ofs;
  logic [NUM_PINS-1:0] src_q, dir_q, drv_q, dout_q, pin_s;

  assign cs  = addr_i[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W];
  assign ofs = ofs_e'(addr_i[OFS_W-1:0]);

  cfg_io_regs #(
    .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .HAS_CTRL(HAS_CTRL), .DIR_BITS(DIR_BITS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_i & cs),
    .ofs_i   (ofs),
    .wdata_i (wdata_i),
    .src_o   (src_q),
    .dir_o   (dir_q),
    .drv_o   (drv_q),
    .dout_o  (dout_q)
  );

  cfg_io_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    cfg_io_pin #(.HAS_OVR(HAS_OE_OVR)) u_pin (
      .src_i        (src_q[g]),
      .dir_i        (dir_q[g]),
      .drv_i        (drv_q[g]),
      .dout_i       (dout_q[g]),
      .addr_bit_i   (addr_bit_i[g]),
      .ext_oe_i     (ext_oe_i[g]),
      .pad_out_o    (pad_out_o[g]),
      .pad_oe_o     (pad_oe_o[g]),
      .open_drain_o (open_drain_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && cs) begin
      case (ofs)
        OFS_SRC:  rdata_o[NUM_PINS-1:0] = src_q;
        OFS_DIR:  rdata_o[NUM_PINS-1:0] = dir_q;
        OFS_DRV:  rdata_o[NUM_PINS-1:0] = drv_q;
        OFS_DOUT: rdata_o[NUM_PINS-1:0] = dout_q;
        OFS_PIN:  rdata_o[NUM_PINS-1:0] = pin_s;
        default:  rdata_o = '0;
      endcase
    end
  end

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_PINS   = 8,
  parameter bit          HAS_OE_OVR = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_i,
  input logic                rd_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] ext_oe_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] open_drain_o
);
  // R1: no pin driven while in reset with no override
  always @(posedge clk_i)
    if (!rst_ni && ext_oe_i == '0)
      a_r1_quiet_in_reset: assert (pad_oe_o == '0);

  // R6: an open-drain pin never drives high
  a_r6_od_no_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_drain_o & pad_oe_o & pad_out_o) == '0);

  // R6: drive style changes only through a write
  a_r6_drv_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(open_drain_o));

  // R11: idle read bus
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  if (HAS_OE_OVR) begin : g_ovr
    // R5: active override on a push-pull pin forces drive
    a_r5_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_oe_i & ~open_drain_o & ~pad_oe_o) == '0);
  end
endmodule

bind cfg_io_port cfg_io_port_chk #(
  .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .HAS_OE_OVR(HAS_OE_OVR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .rdata_o      (rdata_o),
  .ext_oe_i     (ext_oe_i),
  .pad_out_o    (pad_out_o),
  .pad_oe_o     (pad_oe_o),
  .open_drain_o (open_drain_o)
);

// File: tb/sim_cfg_io_port.sv
module sim_cfg_io_port;
  localparam logic [7:0] BASE = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] addr = '0, wdata = '0, addr_bit = '0, ext_oe = '0, pin = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata[2], pout[2], poe[2], pod[2];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  cfg_io_port #(.BASE(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata[0]), .addr_bit_i(addr_bit), .ext_oe_i(ext_oe),
    .pin_i(pin), .pad_out_o(pout[0]), .pad_oe_o(poe[0]), .open_drain_o(pod[0]));

  cfg_io_port #(.BASE(BASE), .HAS_CTRL(1'b0), .HAS_OE_OVR(1'b0), .DIR_BITS(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata[1]), .addr_bit_i(addr_bit), .ext_oe_i(ext_oe),
    .pin_i(pin), .pad_out_o(pout[1]), .pad_oe_o(poe[1]), .open_drain_o(pod[1]));

  // behavioural model
  logic [7:0] m_src[2], m_dir[2], m_drv[2], m_dout[2];
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_src[k] = 0; m_dir[k] = 0; m_drv[k] = 0; m_dout[k] = 0;
      end
      hist = {8'h00, 8'h00};
    end else begin
      if (wr && addr[7:3] == BASE[7:3]) begin
        case (addr[2:0])
          3'd0: m_src[0] = wdata;
          3'd1: begin m_dir[0] = wdata; m_dir[1] = wdata & 8'h0f; end
          3'd2: begin m_drv[0] = wdata; m_drv[1] = wdata; end
          3'd3: begin m_dout[0] = wdata; m_dout[1] = wdata; end
          default: ;
        endcase
      end
      hist.push_back(pin);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic [7:0] exp_val(int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = m_src[k][i] ? addr_bit[i] : m_dout[k][i];
    return v;
  endfunction

  function automatic logic [7:0] exp_out(int k);
    return exp_val(k) & ~m_drv[k];
  endfunction

  function automatic logic [7:0] exp_oe(int k);
    logic [7:0] e, v;
    v = exp_val(k);
    for (int i = 0; i < 8; i++) begin
      e[i] = m_dir[k][i] | (k == 0 && ext_oe[i]);
      if (m_drv[k][i] && v[i]) e[i] = 1'b0;
    end
    return e;
  endfunction

  function automatic logic [7:0] exp_rd(int k);
    if (!rd || addr[7:3] != BASE[7:3]) return 8'h00;
    case (addr[2:0])
      3'd0: return m_src[k];
      3'd1: return m_dir[k];
      3'd2: return m_drv[k];
      3'd3: return m_dout[k];
      3'd4: return hist[hist.size()-2];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < 2; k++) begin
        if (!rst_n) begin
          chk(poe[k] === 8'h00, "R1", "pad_oe in reset", poe[k], 8'h00);
          chk(rdata[k] === 8'h00, "R1", "read in reset", rdata[k], 8'h00);
        end else begin
          string rq;
          chk(poe[k] === exp_oe(k), (k == 1) ? "R10" : ((ext_oe != 0) ? "R5" : "R4"),
              "pad_oe", poe[k], exp_oe(k));
          chk(pout[k] === exp_out(k), (m_drv[k] != 0) ? "R6" : "R3", "pad_out", pout[k], exp_out(k));
          chk(pod[k] === m_drv[k], "R6", "open_drain", pod[k], m_drv[k]);
          if (!rd || addr[7:3] != BASE[7:3] || addr[2:0] > 3'd4) rq = "R11";
          else if (addr[2:0] == 3'd4) rq = "R7";
          else if (k == 1 && addr[2:0] == 3'd1) rq = "R8";
          else if (k == 1 && addr[2:0] == 3'd0) rq = "R9";
          else rq = "R2";
          chk(rdata[k] === exp_rd(k), rq, "rdata", rdata[k], exp_rd(k));
        end
      end
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    @(posedge clk); #1;
    addr = a; rd = 1'b1; wr = 1'b0;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  initial begin
    // R1: read every offset during reset
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1; rd = 1'b1; addr = BASE + 8'(i);
    end
    @(posedge clk); #1; rst_n = 1'b1; rd = 1'b0;

    // R2/R8/R9 write and read back
    bus_wr(BASE + 8'd1, 8'hff);
    bus_rd(BASE + 8'd1);
    bus_wr(BASE + 8'd3, 8'h5a);
    bus_wr(BASE + 8'd0, 8'hf0);
    bus_rd(BASE + 8'd0);
    @(posedge clk); #1; addr_bit = 8'hc3;
    bus_rd(BASE + 8'd3);
    // R2: other base ignored
    bus_wr(8'h80, 8'h00);
    bus_rd(BASE + 8'd1);
    // R6: open drain
    bus_wr(BASE + 8'd2, 8'h0f);
    bus_rd(BASE + 8'd2);
    // R5/R10: override with direction cleared
    bus_wr(BASE + 8'd1, 8'h00);
    @(posedge clk); #1; ext_oe = 8'hff;
    @(posedge clk); #1; ext_oe = 8'h00;
    // R7: pin sampling
    @(posedge clk); #1; pin = 8'ha5; rd = 1'b1; addr = BASE + 8'd4;
    @(posedge clk); #1; pin = 8'h3c;
    @(posedge clk); #1; pin = 8'h0f;
    @(posedge clk); #1; rd = 1'b0;
    // R11: unused offsets
    for (int i = 5; i < 8; i++) bus_rd(BASE + 8'(i));

    // random traffic
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #1;
      addr     = ($urandom_range(0, 7) == 0) ? 8'($urandom) : (BASE | 8'($urandom_range(0, 7)));
      wdata    = 8'($urandom);
      wr       = ($urandom_range(0, 2) == 0);
      rd       = ($urandom_range(0, 1) == 0);
      addr_bit = 8'($urandom);
      ext_oe   = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      pin      = 8'($urandom);
    end
    @(posedge clk); #1; wr = 1'b0; rd = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule